// File: doc/BRIEF.md
# Word-Parallel Memory Scan CRC-16 Engine

This block checks a code memory region by reading it one 32-bit word per clock through a synchronous read port. Each word is folded into a 16-bit CRC remainder in a single cycle. The polynomial is x^16 + x^12 + x^5 + 1 (0x1021), and bits are taken from bit 31 down to bit 0. At full rate, a 64 KB region takes 16384 read cycles.

Software arms the engine through an 8-bit control register. The register holds a run-enable bit and a 6-bit end-of-range field. The scan starts only when the processor signals that it is entering its halt state while the engine is armed. When the last word has been absorbed, the engine loads the remainder into a result register. It then pulses a completion flag and a wake request in the same cycle, which bring the processor out of halt. The engine then returns to idle.

Top module: `memscan_crc16`

## Requirements
- R1: After reset, the control readback is 0x00. The outputs `done`, `wake` and `mem_rd` are 0, and `crc_result` is 0x0000.
- R2: Control layout: bit 7 is the run enable and bits 5:0 are the end field. Bit 6 always reads 0. A write made while idle can be read back in the next cycle, so 0xFF reads as 0xBF.
- R3: While the enable bit is 0, a halt event starts no scan: no memory read and no `done`.
- R4: With the enable bit at 1, a halt event seen at a clock edge while idle asserts `mem_rd` in the next cycle with `mem_addr` = 0. The word address then rises by one each cycle while `mem_rd` stays high.
- R5: With end field F, the scan reads word addresses 0 to (F+1)*256-1 exactly once each, which is (F+1) KB. F = 63 covers 64 KB.
- R6: The result equals the MSB-first CRC with polynomial 0x1021 over the words in ascending address order. Each word goes from bit 31 down to bit 0. The remainder is preset to 0x0000, and there is no reflection and no final inversion.
- R7: `done` and `wake` go high for exactly one cycle, N+2 cycles after the starting edge, where N is the word count. `crc_result` holds the final value from that cycle on.
- R8: Control writes made during a scan are ignored. Both the readback and the scan range are unchanged afterwards.
- R9: Each run needs its own halt event. A halt event during a scan has no effect, and after completion no further reads occur without a new event.
- R10: `crc_result` keeps the previous run's value throughout a scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control write data |
| ctl_rdata | output | 8 | Control register readback |
| halt_evt | input | 1 | Processor entering its halt state (one-cycle pulse) |
| mem_rd | output | 1 | Memory read request |
| mem_addr | output | 14 | Word address of the read |
| mem_rdata | input | 32 | Read data, valid the cycle after the request |
| crc_result | output | 16 | Result register |
| done | output | 1 | One-cycle completion pulse |
| wake | output | 1 | One-cycle wake request ending the halt |

## Verification
A control write becomes visible on the readback in the cycle after the clock edge that takes it. The first read request comes in the cycle after the edge that samples the halt event. Completion follows N+2 cycles after that edge: N issue cycles, one cycle for the memory read latency and one cycle to fold the last word. The bench drives all inputs and samples all outputs on falling edges. It counts falling edges from the start edge, so the completion cycle, the address sequence and the read count are compared against these exact offsets rather than polled loosely.

// File: rtl/memscan_pkg.sv
package memscan_pkg;
  typedef enum logic [1:0] {
    SCAN_IDLE  = 2'd0,
    SCAN_RUN   = 2'd1,
    SCAN_DRAIN = 2'd2
  } scan_state_e;
endpackage

// File: rtl/msc_crc_fold.sv
module msc_crc_fold #(
  parameter int              WORD_W = 32,
  parameter int              CRC_W  = 16,
  parameter logic [CRC_W-1:0] POLY  = 16'h1021
) (
  input  logic [CRC_W-1:0]  crc_in,
  input  logic [WORD_W-1:0] word,
  output logic [CRC_W-1:0]  crc_out
);
  logic [CRC_W-1:0] acc;
  logic             fb;

  // Unrolled serial division, top bit of the word first.
  always_comb begin
    acc = crc_in;
    fb  = 1'b0;
    for (int b = WORD_W - 1; b >= 0; b--) begin
      fb  = acc[CRC_W-1] ^ word[b];
      acc = {acc[CRC_W-2:0], 1'b0};
      if (fb) acc = acc ^ POLY;
    end
    crc_out = acc;
  end
endmodule

// File: rtl/msc_ctl_reg.sv
module msc_ctl_reg #(
  parameter int FIELD_W = 6,
  localparam int CTL_W  = FIELD_W + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               busy,
  input  logic               we,
  input  logic [CTL_W-1:0]   wdata,
  output logic [CTL_W-1:0]   rdata,
  output logic               run_en,
  output logic [FIELD_W-1:0] end_field
);
  logic               en_q, en_d;
  logic [FIELD_W-1:0] fld_q, fld_d;
  logic               wr_ok;
  logic               unused_gap_bit;

  assign unused_gap_bit = wdata[CTL_W-2];
  assign wr_ok          = we && !busy;

  always_comb begin
    en_d  = en_q;
    fld_d = fld_q;
    if (wr_ok) begin
      en_d  = wdata[CTL_W-1];
      fld_d = wdata[FIELD_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      fld_q <= '0;
    end else begin
      en_q  <= en_d;
      fld_q <= fld_d;
    end
  end

  assign rdata     = {en_q, 1'b0, fld_q};
  assign run_en    = en_q;
  assign end_field = fld_q;

  AST_CTL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(en_q) && $stable(fld_q))); // R8
endmodule

// File: rtl/msc_addr_gen.sv
module msc_addr_gen #(
  parameter int FIELD_W    = 6,
  parameter int UNIT_SHIFT = 8,
  localparam int ADDR_W    = FIELD_W + UNIT_SHIFT
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               step,
  input  logic [FIELD_W-1:0] end_field,
  output logic [ADDR_W-1:0]  addr,
  output logic               at_last
);
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [ADDR_W-1:0] last_addr;

  assign last_addr = {end_field, {UNIT_SHIFT{1'b1}}};

  always_comb begin
    addr_d = addr_q;
    if (start)     addr_d = '0;
    else if (step) addr_d = addr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= addr_d;
  end

  assign addr    = addr_q;
  assign at_last = (addr_q == last_addr);

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && $past(step)) |-> (addr_q == $past(addr_q) + 1'b1)); // R4
  AST_ADDR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (addr_q <= last_addr)); // R5
endmodule

// File: rtl/memscan_crc16.sv
module memscan_crc16 #(
  parameter int               WORD_W     = 32,
  parameter int               CRC_W      = 16,
  parameter logic [CRC_W-1:0] POLY       = 16'h1021,
  parameter int               FIELD_W    = 6,
  parameter int               UNIT_BYTES = 1024,
  localparam int              WORD_BYTES = WORD_W / 8,
  localparam int              UNIT_WORDS = UNIT_BYTES / WORD_BYTES,
  localparam int              UNIT_SHIFT = $clog2(UNIT_WORDS),
  localparam int              ADDR_W     = FIELD_W + UNIT_SHIFT,
  localparam int              CTL_W      = FIELD_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic [CTL_W-1:0]  ctl_wdata,
  output logic [CTL_W-1:0]  ctl_rdata,
  input  logic              halt_evt,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic [CRC_W-1:0]  crc_result,
  output logic              done,
  output logic              wake
);
  import memscan_pkg::*;

  logic [1:0]          rst_sync;
  logic                rst_sn;
  scan_state_e         state_q, state_d;
  logic                start, finish, busy, step;
  logic                run_en, at_last;
  logic [FIELD_W-1:0]  end_field;
  logic                rvld_q;
  logic [CRC_W-1:0]    crc_q, crc_d, fold_out;
  logic [CRC_W-1:0]    res_q, res_d;
  logic                done_q, wake_q;

  // Reset: asserted asynchronously, released on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_sn = rst_sync[1];

  msc_ctl_reg #(.FIELD_W(FIELD_W)) u_ctl (
    .clk(clk), .rst_n(rst_sn), .busy(busy), .we(ctl_we), .wdata(ctl_wdata),
    .rdata(ctl_rdata), .run_en(run_en), .end_field(end_field)
  );

  msc_addr_gen #(.FIELD_W(FIELD_W), .UNIT_SHIFT(UNIT_SHIFT)) u_addr (
    .clk(clk), .rst_n(rst_sn), .start(start), .step(step),
    .end_field(end_field), .addr(mem_addr), .at_last(at_last)
  );

  msc_crc_fold #(.WORD_W(WORD_W), .CRC_W(CRC_W), .POLY(POLY)) u_fold (
    .crc_in(crc_q), .word(mem_rdata), .crc_out(fold_out)
  );

  // Next state
  always_comb begin
    state_d = state_q;
    start   = 1'b0;
    finish  = 1'b0;
    unique case (state_q)
      SCAN_IDLE: if (run_en && halt_evt) begin
        start   = 1'b1;
        state_d = SCAN_RUN;
      end
      SCAN_RUN:   if (at_last) state_d = SCAN_DRAIN;
      SCAN_DRAIN: begin
        finish  = 1'b1;
        state_d = SCAN_IDLE;
      end
      default:    state_d = SCAN_IDLE;
    endcase
  end

  assign step = (state_q == SCAN_RUN);
  assign busy = (state_q != SCAN_IDLE);

  always_comb begin
    crc_d = crc_q;
    if (start)       crc_d = '0;
    else if (rvld_q) crc_d = fold_out;
    res_d = finish ? fold_out : res_q;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      state_q <= SCAN_IDLE;
      rvld_q  <= 1'b0;
      crc_q   <= '0;
      res_q   <= '0;
      done_q  <= 1'b0;
      wake_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      rvld_q  <= step;
      crc_q   <= crc_d;
      res_q   <= res_d;
      done_q  <= finish;
      wake_q  <= finish;
    end
  end

  assign mem_rd     = step;
  assign crc_result = res_q;
  assign done       = done_q;
  assign wake       = wake_q;

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_sn)
    done |=> !done); // R7
  AST_NO_START_DISABLED: assert property (@(posedge clk) disable iff (!rst_sn)
    (state_q == SCAN_IDLE && !run_en) |=> (state_q == SCAN_IDLE)); // R3
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_sn)
    (state_q == SCAN_RUN) |=> $stable(crc_result)); // R10
  AST_BUSY_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_sn)
    (state_q == SCAN_RUN && !at_last) |=> (state_q == SCAN_RUN)); // R9
endmodule

// File: tb/sim_memscan_crc16.sv
module sim_memscan_crc16;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_we = 1'b0;
  logic [7:0]  ctl_wdata = 8'h00;
  logic [7:0]  ctl_rdata;
  logic        halt_evt = 1'b0;
  logic        mem_rd;
  logic [13:0] mem_addr;
  logic [31:0] mem_rdata = 32'h0;
  logic [15:0] crc_result;
  logic        done, wake;
  logic [31:0] seed = 32'h0;

  int n_chk = 0, n_fail = 0;
  int rd_total = 0, addr_err = 0, done_total = 0;
  logic        prev_rd = 1'b0;
  logic [13:0] prev_addr = '0;

  always #5 clk = ~clk;

  memscan_crc16 u0 (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .halt_evt(halt_evt), .mem_rd(mem_rd),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .crc_result(crc_result),
    .done(done), .wake(wake)
  );

  function automatic logic [31:0] pat(input logic [13:0] a, input logic [31:0] s);
    return ({18'd0, a} * 32'h9E3779B1) ^ s;
  endfunction

  always @(posedge clk) if (mem_rd) mem_rdata <= pat(mem_addr, seed);

  // Address-sequence and event monitor on falling edges
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_rd) begin
        rd_total++;
        if (!prev_rd && mem_addr != 14'd0) addr_err++;
        if (prev_rd && mem_addr != prev_addr + 14'd1) addr_err++;
      end
      if (done) done_total++;
    end
    prev_rd   = mem_rd;
    prev_addr = mem_addr;
  end

  function automatic logic [15:0] ref_crc(input int fea, input logic [31:0] s);
    logic [15:0] c = 16'h0000;
    logic [31:0] w;
    for (int a = 0; a < (fea + 1) * 256; a++) begin
      w = pat(14'(a), s);
      for (int b = 31; b >= 0; b--) begin
        if (c[15] ^ w[b]) c = {c[14:0], 1'b0} ^ 16'h1021;
        else              c = {c[14:0], 1'b0};
      end
    end
    return c;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_ctl(input logic [7:0] v);
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = v;
    @(negedge clk); ctl_we = 1'b0;
  endtask

  // Full run; perturb = write control to 0 and pulse halt mid-scan
  task automatic run_scan(input int fea, input logic [31:0] s, input bit perturb);
    int          cyc, r0, e0, n;
    logic [15:0] prev_res, exp_crc;
    logic [7:0]  ctl_set;
    n        = (fea + 1) * 256;
    ctl_set  = {2'b10, 6'(fea)};
    exp_crc  = ref_crc(fea, s);
    seed     = s;
    wr_ctl(ctl_set);
    prev_res = crc_result;
    r0 = rd_total; e0 = addr_err;
    halt_evt = 1'b1;
    @(negedge clk); halt_evt = 1'b0;
    cyc = 1;
    chk(mem_rd === 1'b1 && mem_addr === 14'd0, "R4 first read", {17'd0, mem_rd, mem_addr}, 32'h4000);
    while (done !== 1'b1 && cyc < 20000) begin
      if (cyc == 5) begin
        chk(crc_result === prev_res, "R10 result held", crc_result, prev_res);
        if (perturb) begin ctl_we = 1'b1; ctl_wdata = 8'h00; halt_evt = 1'b1; end
      end
      if (cyc == 6) begin ctl_we = 1'b0; halt_evt = 1'b0; end
      @(negedge clk); cyc++;
    end
    chk(cyc == n + 2, "R7 done timing", cyc, n + 2);
    chk(wake === 1'b1, "R7 wake with done", wake, 1);
    chk(crc_result === exp_crc, "R6 crc value", crc_result, exp_crc);
    chk(rd_total - r0 == n, "R5 word count", rd_total - r0, n);
    chk(addr_err == e0, "R4 address order", addr_err - e0, 0);
    @(negedge clk);
    chk(done === 1'b0 && wake === 1'b0, "R7 one-cycle pulse", {done, wake}, 0);
    chk(crc_result === exp_crc, "R7 result kept", crc_result, exp_crc);
    if (perturb) chk(ctl_rdata === ctl_set, "R8 control frozen", ctl_rdata, ctl_set);
  endtask

  localparam int NV = 5;
  localparam logic [37:0] VEC [NV] = '{
    {6'd0,  32'h0000_0000},
    {6'd1,  32'hFFFF_FFFF},
    {6'd3,  32'h1234_5678},
    {6'd0,  32'hA5A5_A5A5},
    {6'd63, 32'h0F0F_3C3C}
  };

  initial begin
    #(200000 * 10);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    int r0, d0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(ctl_rdata === 8'h00, "R1 ctl reset", ctl_rdata, 0);
    chk({done, wake, mem_rd} === 3'b000, "R1 outputs idle", {done, wake, mem_rd}, 0);
    chk(crc_result === 16'h0, "R1 result reset", crc_result, 0);

    wr_ctl(8'hFF);
    chk(ctl_rdata === 8'hBF, "R2 bit6 reads zero", ctl_rdata, 8'hBF);

    // R3: disabled engine ignores halt
    wr_ctl(8'h05);
    r0 = rd_total; d0 = done_total;
    halt_evt = 1'b1; @(negedge clk); halt_evt = 1'b0;
    repeat (10) @(negedge clk);
    chk(rd_total == r0 && done_total == d0, "R3 no start when disabled", rd_total - r0, 0);

    for (int i = 0; i < NV; i++)
      run_scan(int'(VEC[i][37:32]), VEC[i][31:0], 1'b0);

    // R9: no rerun without a new halt event
    r0 = rd_total; d0 = done_total;
    repeat (20) @(negedge clk);
    chk(rd_total == r0 && done_total == d0, "R9 no rerun", rd_total - r0, 0);

    // R8/R9: writes and halt during a scan are ignored
    run_scan(2, 32'hDEAD_BEEF, 1'b1);
    chk(done_total == d0 + 1, "R9 single completion", done_total - d0, 1);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule